// File: doc/BRIEF.md
# Accumulator Stored-Program Processor

A small multi-cycle processor that keeps its program and its data in one internal word-addressed memory. It loops through fetch, decode and execute until it meets a stop instruction. The datapath has one 16-bit working register and a three-flag condition register (greater, equal, less). Every memory access goes through an address register and a data register. A read takes an address step, a decode step and a transfer step. A write loads the address and the value together, then decodes, then transfers.

Each instruction word is 40 bits wide: an 8-bit opcode followed by two 16-bit address fields. Only the low 8 bits of an address select one of the 256 cells. Data values are the low 16 bits of a cell, read as two's complement. Software loads a program through the test port while the core is stopped, pulses `start_i`, waits for `halted_o` and then reads results back through the same port.

Top module: `acc_cpu`

## Requirements
- R1: After reset `halted_o`=1, `r_o`=0, `gt_o`=`eq_o`=`lt_o`=0 and `illegal_o`=0, and the first `start_i` pulse starts execution at cell 0.
- R2: An instruction word holds the opcode in bits [39:32], address X in [31:16] and address Y in [15:0]. Addresses wrap on their low 8 bits, so X=0x0132 selects cell 0x32.
- R3: Opcode 1 loads cell X into R, opcode 2 writes R into cell X, and opcode 3 copies cell X into cell Y. Every write stores the 16-bit value and zeroes bits [39:16] of the cell.
- R4: Opcode 4 sets R to R+mem[X], opcode 10 sets R to R-mem[X], and opcode 9 writes mem[X]+mem[Y] into cell Y. All arithmetic wraps modulo 2^16.
- R5: Opcode 11 compares mem[X] with mem[Y] as signed values and sets exactly one of gt (X>Y), eq and lt. No other instruction changes the flags.
- R6: Opcode 16 always jumps to X. Opcodes 17..22 jump to X when, in order, gt, eq, lt, gt|eq, lt|eq and !eq hold. Otherwise execution goes on at the next cell.
- R7: A read leaves the cell unchanged. With a fetch or data access taking four cycles plus one decode cycle, a lone stop instruction keeps `halted_o` low for 5 cycles, and a load followed by a stop keeps it low for 14.
- R8: Opcode 255 stops the core. `halted_o` stays high until the next `start_i` pulse, and execution then resumes at the following cell.
- R9: Any other opcode stops the core and sets `illegal_o`, leaving R unchanged. `illegal_o` clears on reset or on the next `start_i`.
- R10: A test-port write lands only while `halted_o` is high. `tb_rdata_o` shows cell `tb_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or resume execution from the halted state |
| halted_o | output | 1 | Core is idle |
| illegal_o | output | 1 | Last stop was caused by an unknown opcode |
| r_o | output | 16 | Working register R |
| gt_o | output | 1 | Greater flag |
| eq_o | output | 1 | Equal flag |
| lt_o | output | 1 | Less flag |
| tb_we_i | input | 1 | Test-port write enable (honoured only while halted) |
| tb_addr_i | input | 8 | Test-port cell address |
| tb_wdata_i | input | 40 | Test-port write word |
| tb_rdata_o | output | 40 | Test-port read word |

## Verification
A wrong sequencer state mostly shows up as a changed halt time. The 5- and 14-cycle windows catch a missing or extra access step on the first instruction. A wrong operand mux or a wrong flag decode reaches `r_o` or a result cell one instruction later. The bench covers this by walking all six conditional jumps against each of the three compare outcomes. A write that leaks its upper bits or lands in the wrong row shows on the test port as soon as the core halts.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPW = 8;

  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 8'd1,  OP_STORE = 8'd2,  OP_MOVE = 8'd3,  OP_ADDR = 8'd4,
    OP_ADDM  = 8'd9,  OP_SUB   = 8'd10, OP_CMP  = 8'd11, OP_JMP  = 8'd16,
    OP_JGT   = 8'd17, OP_JEQ   = 8'd18, OP_JLT  = 8'd19, OP_JGE  = 8'd20,
    OP_JLE   = 8'd21, OP_JNE   = 8'd22, OP_HALT = 8'd255
  } opcode_e;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } ccr_t;

  function automatic logic jump_taken(logic [OPW-1:0] op, ccr_t c);
    case (op)
      OP_JMP:  return 1'b1;
      OP_JGT:  return c.gt;
      OP_JEQ:  return c.eq;
      OP_JLT:  return c.lt;
      OP_JGE:  return c.gt | c.eq;
      OP_JLE:  return c.lt | c.eq;
      OP_JNE:  return ~c.eq;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int WW = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [WW-1:0] mdr_o,
  input  logic          tb_we_i,
  input  logic [AW-1:0] tb_addr_i,
  input  logic [WW-1:0] tb_wdata_i,
  output logic [WW-1:0] tb_rdata_o
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {M_IDLE, M_DEC, M_XFER, M_DONE} mst_e;

  mst_e          st_q;
  logic [AW-1:0] mar_q, row_q;
  logic [WW-1:0] mdr_q;
  logic          we_q;
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= M_IDLE;
      mar_q <= '0;
      row_q <= '0;
      mdr_q <= '0;
      we_q  <= 1'b0;
    end else begin
      case (st_q)
        M_IDLE: if (req_i) begin
          mar_q <= addr_i;
          we_q  <= we_i;
          if (we_i) mdr_q <= {{(WW-DW){1'b0}}, wdata_i};
          st_q  <= M_DEC;
        end
        M_DEC: begin
          row_q <= mar_q;
          st_q  <= M_XFER;
        end
        M_XFER: begin
          if (!we_q) mdr_q <= mem[row_q];
          st_q <= M_DONE;
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (st_q == M_XFER && we_q) mem[row_q] <= mdr_q;
    else if (tb_we_i)           mem[tb_addr_i] <= tb_wdata_i;
  end

  assign done_o     = (st_q == M_DONE);
  assign mdr_o      = mdr_q;
  assign tb_rdata_o = mem[tb_addr_i];

  p_read_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == M_XFER && !we_q) |=> mem[$past(row_q)] == $past(mem[row_q]));
  p_write_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == M_XFER && we_q) |=> mem[$past(row_q)][WW-1:DW] == '0);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] diff_o,
  output ccr_t          cmp_o
);
  assign sum_o  = a_i + b_i;
  assign diff_o = a_i - b_i;

  always_comb begin
    cmp_o.gt = $signed(a_i) >  $signed(b_i);
    cmp_o.eq = a_i == b_i;
    cmp_o.lt = $signed(a_i) <  $signed(b_i);
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int FW = 16,
  parameter int WW = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          done_i,
  input  logic [WW-1:0] mdr_i,
  input  logic [DW-1:0] sum_i,
  input  logic [DW-1:0] diff_i,
  input  ccr_t          cmp_i,
  output logic [DW-1:0] opa_o,
  output logic [DW-1:0] opb_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          halted_o,
  output logic          illegal_o,
  output logic [DW-1:0] r_o,
  output ccr_t          ccr_o
);
  typedef enum logic [2:0] {C_IDLE, C_FETCH, C_DEC, C_RD1, C_RD2, C_WR} cst_e;

  cst_e           st_q;
  logic [OPW-1:0] op_q;
  logic [AW-1:0]  ax_q, ay_q, pc_q, addr_q, nxt_pc;
  logic [DW-1:0]  r_q, tmp_q, wdata_q, data;
  ccr_t           ccr_q;
  logic           req_q, we_q, ill_q;

  assign data   = mdr_i[DW-1:0];
  assign nxt_pc = jump_taken(op_q, ccr_q) ? ax_q : pc_q;
  assign opa_o  = (st_q == C_RD2) ? tmp_q : r_q;
  assign opb_o  = data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= C_IDLE;  op_q <= '0;  ax_q <= '0;  ay_q <= '0;  pc_q <= '0;
      r_q  <= '0;      tmp_q <= '0; ccr_q <= '0; ill_q <= 1'b0;
      req_q <= 1'b0;   we_q <= 1'b0; addr_q <= '0; wdata_q <= '0;
    end else begin
      req_q <= 1'b0;
      case (st_q)
        C_IDLE: if (start_i) begin
          ill_q <= 1'b0;
          req_q <= 1'b1; we_q <= 1'b0; addr_q <= pc_q; st_q <= C_FETCH;
        end
        C_FETCH: if (done_i) begin
          op_q <= mdr_i[WW-1 -: OPW];
          ax_q <= mdr_i[FW +: AW];
          ay_q <= mdr_i[0 +: AW];
          pc_q <= pc_q + 1'b1;
          st_q <= C_DEC;
        end
        C_DEC: case (op_q)
          OP_LOAD, OP_ADDR, OP_SUB, OP_MOVE, OP_ADDM, OP_CMP: begin
            req_q <= 1'b1; we_q <= 1'b0; addr_q <= ax_q; st_q <= C_RD1;
          end
          OP_STORE: begin
            req_q <= 1'b1; we_q <= 1'b1; addr_q <= ax_q; wdata_q <= r_q;
            st_q <= C_WR;
          end
          OP_JMP, OP_JGT, OP_JEQ, OP_JLT, OP_JGE, OP_JLE, OP_JNE: begin
            pc_q  <= nxt_pc;
            req_q <= 1'b1; we_q <= 1'b0; addr_q <= nxt_pc; st_q <= C_FETCH;
          end
          OP_HALT: st_q <= C_IDLE;
          default: begin
            ill_q <= 1'b1;
            st_q  <= C_IDLE;
          end
        endcase
        C_RD1: if (done_i) begin
          req_q <= 1'b1;
          we_q  <= 1'b0;
          addr_q <= pc_q;
          st_q  <= C_FETCH;
          case (op_q)
            OP_LOAD: r_q <= data;
            OP_ADDR: r_q <= sum_i;
            OP_SUB:  r_q <= diff_i;
            OP_MOVE: begin
              we_q <= 1'b1; addr_q <= ay_q; wdata_q <= data; st_q <= C_WR;
            end
            default: begin
              tmp_q <= data; addr_q <= ay_q; st_q <= C_RD2;
            end
          endcase
        end
        C_RD2: if (done_i) begin
          req_q <= 1'b1;
          if (op_q == OP_ADDM) begin
            we_q <= 1'b1; addr_q <= ay_q; wdata_q <= sum_i; st_q <= C_WR;
          end else begin
            ccr_q <= cmp_i;
            we_q <= 1'b0; addr_q <= pc_q; st_q <= C_FETCH;
          end
        end
        C_WR: if (done_i) begin
          req_q <= 1'b1; we_q <= 1'b0; addr_q <= pc_q; st_q <= C_FETCH;
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  assign req_o     = req_q;
  assign we_o      = we_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign halted_o  = (st_q == C_IDLE);
  assign illegal_o = ill_q;
  assign r_o       = r_q;
  assign ccr_o     = ccr_q;

  p_halt_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !start_i) |=> halted_o);
  p_illegal_halted_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> halted_o);
  p_flags_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ccr_q));
  p_cmp_sets_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == C_RD2 && done_i && op_q == OP_CMP) |=> $countones(ccr_q) == 1);
  p_flags_only_cmp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != C_RD2) |=> $stable(ccr_q));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int FW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              halted_o,
  output logic              illegal_o,
  output logic [DW-1:0]     r_o,
  output logic              gt_o,
  output logic              eq_o,
  output logic              lt_o,
  input  logic              tb_we_i,
  input  logic [AW-1:0]     tb_addr_i,
  input  logic [OPW+2*FW-1:0] tb_wdata_i,
  output logic [OPW+2*FW-1:0] tb_rdata_o
);
  localparam int WW = OPW + 2 * FW;

  logic          req, we, done, halted;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, opa, opb, sum, diff;
  logic [WW-1:0] mdr;
  ccr_t          cmp, ccr;

  acc_mem #(.AW(AW), .DW(DW), .WW(WW)) u_mem (
    .clk_i, .rst_ni,
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .done_o(done), .mdr_o(mdr),
    .tb_we_i(tb_we_i & halted), .tb_addr_i, .tb_wdata_i, .tb_rdata_o
  );

  acc_alu #(.DW(DW)) u_alu (
    .a_i(opa), .b_i(opb), .sum_o(sum), .diff_o(diff), .cmp_o(cmp)
  );

  acc_ctrl #(.AW(AW), .DW(DW), .FW(FW), .WW(WW)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .done_i(done), .mdr_i(mdr), .sum_i(sum), .diff_i(diff), .cmp_i(cmp),
    .opa_o(opa), .opb_o(opb), .req_o(req), .we_o(we), .addr_o(addr),
    .wdata_o(wdata), .halted_o(halted), .illegal_o, .r_o, .ccr_o(ccr)
  );

  assign halted_o = halted;
  assign gt_o     = ccr.gt;
  assign eq_o     = ccr.eq;
  assign lt_o     = ccr.lt;
endmodule

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        halted_o, illegal_o, gt_o, eq_o, lt_o;
  logic [15:0] r_o;
  logic        tb_we_i = 1'b0;
  logic [7:0]  tb_addr_i = '0;
  logic [39:0] tb_wdata_i = '0;
  logic [39:0] tb_rdata_o;
  int          nchk = 0;
  int          nfail = 0;
  int          cyc;

  always #2 clk = ~clk;

  acc_cpu u0 (
    .clk_i(clk), .rst_ni, .start_i, .halted_o, .illegal_o, .r_o,
    .gt_o, .eq_o, .lt_o, .tb_we_i, .tb_addr_i, .tb_wdata_i, .tb_rdata_o
  );

  function automatic logic [39:0] ins(input logic [7:0] op, input logic [15:0] x,
                                      input logic [15:0] y);
    return {op, x, y};
  endfunction

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic poke(input logic [7:0] a, input logic [39:0] w);
    tb_addr_i = a; tb_wdata_i = w; tb_we_i = 1'b1;
    @(negedge clk); tb_we_i = 1'b0;
  endtask

  function automatic logic [39:0] peek(input logic [7:0] a);
    tb_addr_i = a;
    return tb_rdata_o;
  endfunction

  // start pulse, then count cycles with halted_o low; poke_at>0 tries a write while running
  task automatic run(input int poke_at, input logic [7:0] pa, input logic [39:0] pw);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    cyc = 0;
    while (!halted_o && cyc < 4000) begin
      cyc++;
      if (cyc == poke_at) begin
        tb_addr_i = pa; tb_wdata_i = pw; tb_we_i = 1'b1;
      end else tb_we_i = 1'b0;
      @(negedge clk);
    end
    tb_we_i = 1'b0;
    if (cyc >= 4000) check("run timeout", 40'(cyc), 40'd0);
  endtask

  task automatic t_reset_r1();
    do_reset();
    check("R1 halted", 40'(halted_o), 40'd1);
    check("R1 r", 40'(r_o), 40'd0);
    check("R1 flags", 40'({gt_o, eq_o, lt_o}), 40'd0);
    check("R1 illegal", 40'(illegal_o), 40'd0);
    repeat (3) @(negedge clk);
    check("R8 stays halted without start", 40'(halted_o), 40'd1);
  endtask

  task automatic t_transfer_r3();
    do_reset();
    poke(8'd0, ins(8'd1, 16'h0132, 16'h0));
    poke(8'd1, ins(8'd2, 16'd51, 16'h0));
    poke(8'd2, ins(8'd3, 16'd50, 16'd52));
    poke(8'd3, ins(8'd255, 16'h0, 16'h0));
    poke(8'd50, {24'hABCDEF, 16'h1234});
    poke(8'd51, 40'hFF_FFFF_FFFF);
    poke(8'd52, 40'hFF_FFFF_FFFF);
    poke(8'd53, 40'h55);
    run(3, 8'd53, 40'h99);
    check("R2 R3 load wrapped address", 40'(r_o), 40'h1234);
    check("R3 store clears upper bits", peek(8'd51), 40'h1234);
    check("R3 move", peek(8'd52), 40'h1234);
    check("R7 read keeps cell", peek(8'd50), {24'hABCDEF, 16'h1234});
    check("R10 test write ignored while running", peek(8'd53), 40'h55);
    check("R5 flags untouched", 40'({gt_o, eq_o, lt_o}), 40'd0);
  endtask

  task automatic t_arith_r4();
    do_reset();
    poke(8'd0, ins(8'd1, 16'd60, 16'd0));
    poke(8'd1, ins(8'd4, 16'd61, 16'd0));
    poke(8'd2, ins(8'd10, 16'd62, 16'd0));
    poke(8'd3, ins(8'd2, 16'd63, 16'd0));
    poke(8'd4, ins(8'd9, 16'd64, 16'd65));
    poke(8'd5, ins(8'd255, 16'd0, 16'd0));
    poke(8'd60, 40'd5);
    poke(8'd61, 40'd7);
    poke(8'd62, 40'd20);
    poke(8'd63, 40'd0);
    poke(8'd64, 40'h7FFF);
    poke(8'd65, 40'h1);
    run(0, 8'd0, 40'd0);
    check("R4 add/sub into R", 40'(r_o), 40'hFFF8);
    check("R4 stored negative", peek(8'd63), 40'hFFF8);
    check("R4 mem add wraps into Y", peek(8'd65), 40'h8000);
    check("R4 X unchanged", peek(8'd64), 40'h7FFF);
  endtask

  task automatic t_cycles_r7();
    do_reset();
    poke(8'd0, ins(8'd255, 16'd0, 16'd0));
    run(0, 8'd0, 40'd0);
    check("R7 halt-only cycles", 40'(cyc), 40'd5);
    do_reset();
    poke(8'd0, ins(8'd1, 16'd60, 16'd0));
    poke(8'd1, ins(8'd255, 16'd0, 16'd0));
    run(0, 8'd0, 40'd0);
    check("R7 load+halt cycles", 40'(cyc), 40'd14);
  endtask

  // rel: 0 lt, 1 eq, 2 gt
  task automatic t_jump_r6();
    logic [15:0] av [3];
    logic [15:0] bv [3];
    av[0] = 16'hFFFF; bv[0] = 16'h0001;
    av[1] = 16'h0003; bv[1] = 16'h0003;
    av[2] = 16'h0005; bv[2] = 16'hFFFE;
    poke(8'd72, 40'd1);
    poke(8'd73, 40'd2);
    for (int rel = 0; rel < 3; rel++) begin
      for (int op = 16; op <= 22; op++) begin
        logic tk;
        case (op)
          16: tk = 1'b1;
          17: tk = (rel == 2);
          18: tk = (rel == 1);
          19: tk = (rel == 0);
          20: tk = (rel != 0);
          21: tk = (rel != 2);
          default: tk = (rel != 1);
        endcase
        do_reset();
        poke(8'd0, ins(8'd11, 16'd70, 16'd71));
        poke(8'd1, ins(8'(op), 16'h0104, 16'd0));
        poke(8'd2, ins(8'd1, 16'd72, 16'd0));
        poke(8'd3, ins(8'd255, 16'd0, 16'd0));
        poke(8'd4, ins(8'd1, 16'd73, 16'd0));
        poke(8'd5, ins(8'd255, 16'd0, 16'd0));
        poke(8'd70, {24'd0, av[rel]});
        poke(8'd71, {24'd0, bv[rel]});
        run(0, 8'd0, 40'd0);
        check($sformatf("R6 op %0d rel %0d", op, rel), 40'(r_o), tk ? 40'd2 : 40'd1);
        check($sformatf("R5 flags rel %0d", rel), 40'({gt_o, eq_o, lt_o}),
              40'(3'b001 << rel));
      end
    end
  endtask

  task automatic t_illegal_r9();
    do_reset();
    poke(8'd0, ins(8'd1, 16'd72, 16'd0));
    poke(8'd1, ins(8'h30, 16'd0, 16'd0));
    poke(8'd2, ins(8'd1, 16'd73, 16'd0));
    poke(8'd3, ins(8'd255, 16'd0, 16'd0));
    poke(8'd72, 40'd1);
    poke(8'd73, 40'd2);
    run(0, 8'd0, 40'd0);
    check("R9 illegal flag", 40'(illegal_o), 40'd1);
    check("R9 R unchanged", 40'(r_o), 40'd1);
    run(0, 8'd0, 40'd0);
    check("R9 cleared on start", 40'(illegal_o), 40'd0);
    check("R8 resumes at next cell", 40'(r_o), 40'd2);
    poke(8'd1, ins(8'h30, 16'd0, 16'd0));
    do_reset();
    run(0, 8'd0, 40'd0);
    check("R9 set again", 40'(illegal_o), 40'd1);
    do_reset();
    check("R1 R9 cleared on reset", 40'(illegal_o), 40'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_transfer_r3();
    t_arith_r4();
    t_cycles_r7();
    t_jump_r6();
    t_illegal_r9();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule